// File: doc/BRIEF.md
# Lookup-Multiplexer ALU Slice

A purely combinational, cascadable ALU slice that contains no dedicated adder. For each bit, the A input, after an optional inversion, and the B input index two small truth tables. One table gives a propagate term and the other gives a generate term. The bit result is the propagate term XOR the carry entering that bit. When the function is arithmetic, the carries follow the usual generate/propagate recurrence, so the same lookups yield a sum. When the function is logical, the carry chain is held at zero, so the result is the propagate term alone.

Carry-out is not taken from the last bit of the internal chain. A separate group term is formed from the per-bit lookups, and carry-in enters it through a single AND/OR level. Subtraction computes B minus A: A is inverted and carry-in is driven high. Slices chain into wider ALUs by feeding one slice's carry-out into the next slice's carry-in. A carry-out of 0 from a subtracting slice acts as a borrow.

Top module: `mux_alu_slice`

## Requirements
- R1: With fsel = 5'b10000 (ADD), {cout, y} equals opa + opb + cin; for example, opa = 0100, opb = 1101, cin = 0 gives y = 0001 and cout = 1.
- R2: With fsel = 5'b11000 (SUB), {cout, y} equals opb + ~opa + cin. With cin = 1 this is opb - opa, and cout = 1 means no borrow.
- R3: Logic codes with fsel[4] = 0 give: 3'b001 XOR, 3'b010 XNOR, 3'b011 AND, 3'b100 OR, 3'b101 pass A, 3'b110 pass B, all taken on fsel[2:0]. fsel[3] = 1 inverts opa first, so 5'b01101 gives NOT A. The value of y does not depend on cin.
- R4: When fsel[4] = 0, cout is 0 for every opa, opb and cin.
- R5: Unused codes give y = 0 and cout = 0. These are fsel[2:0] = 3'b111, fsel[4] = 1 with fsel[2:0] other than 3'b000, and fsel[4] = 0 with fsel[2:0] = 3'b000.
- R6: Two slices, with the low slice's cout wired to the high slice's cin, give the full 8-bit sum (ADD) or difference (SUB), including the final carry. For example, 41 - 3 = 0010_0110 with low carry 1, and 34 - 5 = 0001_1101 with low carry 0.
- R7: XNOR (fsel = 5'b00010) of equal operands gives y = all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | Operand A (inverted when fsel[3] = 1) |
| opb | input | WIDTH | Operand B |
| fsel | input | 5 | Function select: [4] carry chain enable, [3] invert A, [2:0] truth-table pair |
| cin | input | 1 | Carry into the slice |
| y | output | WIDTH | Result |
| cout | output | 1 | Carry out of the slice, from the group lookahead path |

## Verification
The hardest cases to reach are those where the fast carry-out path and the internal ripple could disagree. These are full propagate runs, where carry-in alone decides carry-out, and the borrow that passes between chained slices during subtraction. The bench exhausts every operand, carry-in and select value on one slice. It then drives a two-slice chain through all 8-bit operand pairs for ADD and SUB with both carry-in values, so every propagate length and every borrow handoff is exercised.

// File: rtl/mux_alu_slice.sv
`timescale 1ns/1ps
module mux_alu_slice #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [4:0]       fsel,
  input  logic             cin,
  output logic [WIDTH-1:0] y,
  output logic             cout
);
  localparam logic [2:0] K_ARITH = 3'd0;
  localparam logic [2:0] K_XOR   = 3'd1;
  localparam logic [2:0] K_XNOR  = 3'd2;
  localparam logic [2:0] K_AND   = 3'd3;
  localparam logic [2:0] K_OR    = 3'd4;
  localparam logic [2:0] K_PASSA = 3'd5;
  localparam logic [2:0] K_PASSB = 3'd6;

  logic [2:0] code;
  logic       chain_en, inv_a, legal;
  logic [3:0] ptab, gtab;
  logic [WIDTH-1:0] p, g;
  logic [WIDTH:0]   c;
  logic grp_g, grp_p;

  assign code     = fsel[2:0];
  assign chain_en = fsel[4];
  assign inv_a    = fsel[3];
  assign legal    = (code != 3'd7) && (chain_en == (code == K_ARITH));

  always_comb begin
    ptab = 4'b0000;
    gtab = 4'b0000;
    if (legal) begin
      case (code)
        K_ARITH: begin ptab = 4'b0110; gtab = 4'b1000; end
        K_XOR:   ptab = 4'b0110;
        K_XNOR:  ptab = 4'b1001;
        K_AND:   ptab = 4'b1000;
        K_OR:    ptab = 4'b1110;
        K_PASSA: ptab = 4'b1100;
        K_PASSB: ptab = 4'b1010;
        default: ptab = 4'b0000;
      endcase
    end
  end

  assign c[0] = chain_en & legal & cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [1:0] sel;
    assign sel      = {opa[i] ^ inv_a, opb[i]};
    assign p[i]     = ptab[sel];
    assign g[i]     = gtab[sel];
    assign y[i]     = p[i] ^ c[i];
    assign c[i+1]   = g[i] | (p[i] & c[i]);
  end

  always_comb begin
    grp_g = 1'b0;
    grp_p = 1'b1;
    for (int i = 0; i < WIDTH; i++) begin
      grp_g = g[i] | (p[i] & grp_g);
      grp_p = grp_p & p[i];
    end
  end

  assign cout = grp_g | (grp_p & c[0]);
endmodule

// File: rtl/mux_alu_slice_chk.sv
`timescale 1ns/1ps
module mux_alu_slice_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [4:0]       fsel,
  input logic             cin,
  input logic [WIDTH-1:0] y,
  input logic             cout
);
  logic [WIDTH:0] add_ref, sub_ref;
  logic unused_code;

  always_comb begin
    add_ref = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};
    sub_ref = {1'b0, ~opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};
    unused_code = (fsel[2:0] == 3'b111) || (fsel[4] && fsel[2:0] != 3'b000)
                  || (!fsel[4] && fsel[2:0] == 3'b000);
  end

  always_comb begin
    if (fsel == 5'b10000)
      p_add_sum_r1: assert ({cout, y} == add_ref) else $error("R1 add mismatch");
    if (fsel == 5'b11000)
      p_sub_diff_r2: assert ({cout, y} == sub_ref) else $error("R2 sub mismatch");
    if (fsel == 5'b00001)
      p_xor_r3: assert (y == (opa ^ opb)) else $error("R3 xor mismatch");
    if (!fsel[4])
      p_logic_nocarry_r4: assert (!cout) else $error("R4 carry in logic op");
    if (unused_code)
      p_unused_zero_r5: assert (y == '0 && !cout) else $error("R5 unused code output");
    if (fsel == 5'b00010 && opa == opb)
      p_xnor_equal_r7: assert (&y) else $error("R7 xnor equal not all ones");
  end
endmodule

bind mux_alu_slice mux_alu_slice_chk #(.WIDTH(WIDTH)) u_chk (
  .opa(opa), .opb(opb), .fsel(fsel), .cin(cin), .y(y), .cout(cout)
);

// File: tb/sim_mux_alu_slice.sv
`timescale 1ns/1ps
module sim_mux_alu_slice;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  logic [3:0] opa, opb, y;
  logic [4:0] fsel;
  logic cin, cout;

  logic [7:0] a8, b8;
  logic [4:0] f8;
  logic c8, c_mid, c_top;
  logic [3:0] ylo, yhi;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  mux_alu_slice #(.WIDTH(4)) u0 (.opa(opa), .opb(opb), .fsel(fsel), .cin(cin), .y(y), .cout(cout));
  mux_alu_slice #(.WIDTH(4)) u_lo (.opa(a8[3:0]), .opb(b8[3:0]), .fsel(f8), .cin(c8), .y(ylo), .cout(c_mid));
  mux_alu_slice #(.WIDTH(4)) u_hi (.opa(a8[7:4]), .opb(b8[7:4]), .fsel(f8), .cin(c_mid), .y(yhi), .cout(c_top));

  function automatic logic [4:0] model(input logic [3:0] a, input logic [3:0] b,
                                       input logic [4:0] f, input logic ci);
    logic [3:0] ax;
    ax = f[3] ? ~a : a;
    if (f[4]) begin
      if (f[2:0] == 3'b000) return {1'b0, ax} + {1'b0, b} + {4'b0, ci};
      return 5'b0;
    end
    case (f[2:0])
      3'b001: return {1'b0, ax ^ b};
      3'b010: return {1'b0, ~(ax ^ b)};
      3'b011: return {1'b0, ax & b};
      3'b100: return {1'b0, ax | b};
      3'b101: return {1'b0, ax};
      3'b110: return {1'b0, b};
      default: return 5'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] a, input logic [3:0] b, input logic [4:0] f, input logic ci);
    opa = a; opb = b; fsel = f; cin = ci;
    #0.2;
  endtask

  // {opa, opb, fsel, cin, expected y, expected cout}
  localparam logic [18:0] VEC [12] = '{
    {4'b0100, 4'b1101, 5'b10000, 1'b0, 4'b0001, 1'b1},  // R1
    {4'b1111, 4'b0001, 5'b10000, 1'b0, 4'b0000, 1'b1},  // R1
    {4'b1111, 4'b0000, 5'b10000, 1'b1, 4'b0000, 1'b1},  // R1 propagate run
    {4'b0011, 4'b1001, 5'b11000, 1'b1, 4'b0110, 1'b1},  // R2
    {4'b0101, 4'b0010, 5'b11000, 1'b1, 4'b1101, 1'b0},  // R2 borrow
    {4'b1100, 4'b1010, 5'b00001, 1'b1, 4'b0110, 1'b0},  // R3 xor
    {4'b1100, 4'b1010, 5'b00011, 1'b0, 4'b1000, 1'b0},  // R3 and
    {4'b1100, 4'b1010, 5'b00100, 1'b1, 4'b1110, 1'b0},  // R3 or
    {4'b1001, 4'b0000, 5'b01101, 1'b0, 4'b0110, 1'b0},  // R3 not a
    {4'b1111, 4'b1111, 5'b10001, 1'b1, 4'b0000, 1'b0},  // R5
    {4'b1111, 4'b1111, 5'b00000, 1'b1, 4'b0000, 1'b0},  // R5
    {4'b0110, 4'b0110, 5'b00010, 1'b1, 4'b1111, 1'b0}   // R7
  };

  initial begin
    #(8.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    opa = '0; opb = '0; fsel = '0; cin = 1'b0;
    a8 = '0; b8 = '0; f8 = '0; c8 = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 reset idle", {4'b0, cout, y}, 9'h0);
    rst = 1'b0;

    @(negedge clk);
    foreach (VEC[i]) begin
      drive(VEC[i][18:15], VEC[i][14:11], VEC[i][10:6], VEC[i][5]);
      check($sformatf("R1-R7 vector %0d", i), {4'b0, cout, y}, {4'b0, VEC[i][0], VEC[i][4:1]});
    end

    for (int f = 0; f < 32; f++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int ci = 0; ci < 2; ci++) begin
            logic [4:0] e;
            drive(4'(a), 4'(b), 5'(f), 1'(ci));
            e = model(4'(a), 4'(b), 5'(f), 1'(ci));
            if (f[4] == 1'b0) check("R4 logic carry", {8'b0, cout}, 9'b0);
            if (f == 5'b00010 && a == b) check("R7 xnor equal", {5'b0, y}, 9'h0F);
            check("R1 R2 R3 R5 sweep", {4'b0, cout, y}, {4'b0, e});
          end

    // cout must not follow cin in a logic op while y stays fixed
    drive(4'b1010, 4'b0101, 5'b00100, 1'b0);
    check("R3 cin ignored", {4'b0, cout, y}, 9'h0F);
    drive(4'b1010, 4'b0101, 5'b00100, 1'b1);
    check("R3 cin ignored", {4'b0, cout, y}, 9'h0F);

    f8 = 5'b11000; c8 = 1'b1; a8 = 8'd3; b8 = 8'd41; #0.2;
    check("R6 41-3", {c_mid, yhi, ylo}, {1'b1, 8'b0010_0110});
    a8 = 8'd5; b8 = 8'd34; #0.2;
    check("R6 34-5", {c_mid, yhi, ylo}, {1'b0, 8'b0001_1101});

    for (int op = 0; op < 2; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          for (int ci = 0; ci < 2; ci++) begin
            logic [8:0] e;
            f8 = op ? 5'b11000 : 5'b10000;
            a8 = 8'(a); b8 = 8'(b); c8 = 1'(ci);
            #0.1;
            e = op ? ({1'b0, ~a8} + {1'b0, b8} + {8'b0, c8})
                   : ({1'b0, a8} + {1'b0, b8} + {8'b0, c8});
            check("R6 chain", {c_top, yhi, ylo}, e);
          end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule